// File: doc/BRIEF.md
# Page-Write EEPROM Host Controller

This block sits between on-chip logic and a byte-wide parallel EEPROM that has 65,536 locations. The bus has a 16-bit address, an 8-bit data path split into drive, enable and sample wires, and three active-low strobes: chip enable, output enable and write enable. The controller has two kinds of request.

- **Page burst write.** The client first fills an internal page buffer through a simple write port. It then asks for a burst of 1 to 128 bytes starting at a 16-bit address. The controller checks that the burst stays inside one 128-byte page. It issues every byte as a separate strobed write cycle, and the cycles follow each other with a fixed short gap. The device then runs its own internal write, which needs no erase and is timed by the device.
- **Single-byte read.** The controller runs one read cycle and returns the byte.

After the last byte of a burst, the controller does not wait for a fixed worst-case write time. It reads back the last written address over and over and watches data bit 6. While the device is busy, that bit flips on every read. The first time two reads in a row agree, the write is over and the controller reports completion. A cycle-count limit bounds the polling, which takes about 10 ms at the default clock. If the limit is reached, the controller reports a timeout and goes back to idle.

A burst that would cross a page boundary, or has a length of zero or more than a page, is refused as a whole. It is never split.

Top module: `eeprom_page_host`

## Requirements
- R1: After reset and whenever idle, all three strobes are high, the data drive enable is low, `req_ready` is high and all result pulses are low.
- R2: A write request with length 0, length above 128, or low address bits (bits 6:0) plus length above 128 gives a one-cycle `req_reject` pulse in the next cycle. No strobe falls and the controller stays ready.
- R3: An accepted write spends one cycle fetching from the buffer. Then each byte k runs one setup cycle (CE low, OE high, WE high, data driven), STROBE_CYC cycles with WE low, and one hold cycle with WE high. Each cycle of byte k drives address start+k and buffer entry k.
- R4: Within a burst, WE stays high for exactly 2 cycles between successive low pulses, which never exceeds the GAP_MAX_CYC limit.
- R5: WE is never low while OE is low, and the data bus is driven only while OE is high.
- R6: After the hold cycle of the last byte, the controller polls. Each poll is ACCESS_CYC cycles of CE and OE low at the last written address, sampled on the final cycle, followed by one recovery cycle with all strobes high.
- R7: When a poll sample's bit 6 equals bit 6 of the previous poll sample, `wr_done` pulses for one cycle in the next cycle and the controller is ready again. The first poll of a burst can never complete it.
- R8: Polling counts cycles from its first read cycle. If the count has reached POLL_LIMIT by the end of a recovery cycle with no completion, `wr_timeout` pulses for one cycle in the next cycle and the controller returns to idle.
- R9: A read request drives CE and OE low at the given address for ACCESS_CYC cycles. In the next cycle, `rd_valid` pulses and `rd_data` holds the bus byte sampled in the last of those cycles.
- R10: Requests presented while `req_ready` is low are ignored and leave the bus sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_we | input | 1 | Page buffer write strobe |
| buf_idx | input | 7 | Page buffer entry index |
| buf_wdata | input | 8 | Page buffer write data |
| req_valid | input | 1 | Request present (taken only while ready) |
| req_write | input | 1 | 1 = page burst write, 0 = single read |
| req_addr | input | 16 | Start address |
| req_len | input | 8 | Burst length in bytes (writes only) |
| req_ready | output | 1 | Controller idle and able to take a request |
| wr_done | output | 1 | One-cycle pulse: internal write finished |
| wr_timeout | output | 1 | One-cycle pulse: polling limit reached |
| req_reject | output | 1 | One-cycle pulse: write request refused |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` valid |
| rd_data | output | 8 | Byte returned by a read |
| bus_addr | output | 16 | EEPROM address |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_dq_o | output | 8 | Data driven toward the EEPROM |
| bus_dq_oe | output | 1 | Drive enable for `bus_dq_o` |
| bus_dq_i | input | 8 | Data returned by the EEPROM |

## Verification
Every result has a fixed delay from the request edge, and the bench computes that delay for each one:
- The first write setup cycle comes two cycles after acceptance, one fetch cycle later.
- `req_reject` comes one cycle after acceptance.
- `rd_valid` comes ACCESS_CYC+1 cycles after acceptance.
- `wr_done` and `wr_timeout` come one cycle after the poll sample or recovery cycle that decides them.

When a request is accepted, the bench's behavioural model pushes one expected vector for every cycle from the accepting cycle to the final pulse. The number of poll rounds comes from the number of toggling reads that the bench's device model is set to produce. On every falling clock edge the bench pops one vector and compares it with all outputs, so any early or late strobe, address, data or pulse shows up as a miscompare.

// File: rtl/eph_pkg.sv
package eph_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WSET,
    ST_WPULSE,
    ST_WHOLD,
    ST_PREAD,
    ST_PREC,
    ST_RREAD
  } eph_state_t;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } eph_strobe_t;

  localparam eph_strobe_t STROBE_QUIET = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

  // Bus strobe levels for each sequencer state.
  function automatic eph_strobe_t strobe_of(eph_state_t s);
    eph_strobe_t r;
    r = STROBE_QUIET;
    case (s)
      ST_WSET, ST_WHOLD: begin
        r.ce_n  = 1'b0;
        r.dq_oe = 1'b1;
      end
      ST_WPULSE: begin
        r.ce_n  = 1'b0;
        r.we_n  = 1'b0;
        r.dq_oe = 1'b1;
      end
      ST_PREAD, ST_RREAD: begin
        r.ce_n = 1'b0;
        r.oe_n = 1'b0;
      end
      default: r = STROBE_QUIET;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/eph_pagebuf.sv
// Page staging buffer: one write port, one synchronous read port, no reset on
// the storage or read register so that it maps onto block RAM.
module eph_pagebuf #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/eph_req_check.sv
// Page-boundary legality check for a burst write request.
module eph_req_check #(
  parameter int PAGE_BYTES = 128,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int LEN_W = $clog2(PAGE_BYTES + 1),
  localparam int SUM_W = LEN_W + 1
) (
  input  logic [OFF_W-1:0] offset,
  input  logic [LEN_W-1:0] len,
  output logic             ok
);

  logic [SUM_W-1:0] reach;

  always_comb begin
    reach = SUM_W'(offset) + SUM_W'(len);
    ok    = (len != '0) && (len <= LEN_W'(PAGE_BYTES)) && (reach <= SUM_W'(PAGE_BYTES));
  end

endmodule

// File: rtl/eph_seq.sv
// Bus sequencer: strobed byte writes, toggle-bit completion polling with a
// cycle-count limit, and single reads.
module eph_seq
  import eph_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 128,
  parameter int ACCESS_CYC  = 4,
  parameter int STROBE_CYC  = 3,
  parameter int GAP_MAX_CYC = 4,
  parameter int POLL_LIMIT  = 500000,
  parameter int TOGGLE_BIT  = 6,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int LEN_W = $clog2(PAGE_BYTES + 1),
  localparam int PH_MAX = (ACCESS_CYC > STROBE_CYC) ? ACCESS_CYC : STROBE_CYC,
  localparam int PH_W  = $clog2(PH_MAX + 1),
  localparam int PC_W  = $clog2(POLL_LIMIT + 1),
  localparam int GAP_W = $clog2(GAP_MAX_CYC + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_ok,
  output logic [OFF_W-1:0]  buf_raddr,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              ready,
  output logic              done,
  output logic              timeout,
  output logic              reject,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_ce_n,
  output logic              bus_oe_n,
  output logic              bus_we_n,
  output logic [DATA_W-1:0] bus_dq_o,
  output logic              bus_dq_oe,
  input  logic [DATA_W-1:0] bus_dq_i
);

  localparam logic [PH_W-1:0]  PH_ACC_END = PH_W'(ACCESS_CYC - 1);
  localparam logic [PH_W-1:0]  PH_STB_END = PH_W'(STROBE_CYC - 1);
  localparam logic [PC_W-1:0]  PC_LAST    = PC_W'(POLL_LIMIT - 1);
  localparam logic [GAP_W-1:0] GAP_SAT    = GAP_W'(GAP_MAX_CYC + 1);

  eph_state_t        state, nxt;
  eph_strobe_t       strb_q;
  logic [PH_W-1:0]   ph;
  logic [OFF_W-1:0]  cnt, last_k;
  logic [ADDR_W-1:0] addr_q;
  logic [PC_W-1:0]   pc;
  logic              have_prev, prev_b6;
  logic              done_q, tmo_q, rej_q, rdv_q;
  logic [DATA_W-1:0] rd_q;

  logic acc_end, stb_end, last_byte, settled, expired;

  always_comb begin
    acc_end   = (ph == PH_ACC_END);
    stb_end   = (ph == PH_STB_END);
    last_byte = (cnt == last_k);
    settled   = have_prev && (bus_dq_i[TOGGLE_BIT] == prev_b6);
    expired   = (pc >= PC_LAST);
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (req_valid) nxt = req_write ? (req_ok ? ST_FETCH : ST_IDLE) : ST_RREAD;
      ST_FETCH:  nxt = ST_WSET;
      ST_WSET:   nxt = ST_WPULSE;
      ST_WPULSE: if (stb_end) nxt = ST_WHOLD;
      ST_WHOLD:  nxt = last_byte ? ST_PREAD : ST_WSET;
      ST_PREAD:  if (acc_end) nxt = settled ? ST_IDLE : ST_PREC;
      ST_PREC:   nxt = expired ? ST_IDLE : ST_PREAD;
      ST_RREAD:  if (acc_end) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  // Next entry is fetched during the hold cycle so it is ready at setup.
  assign buf_raddr = (state == ST_WHOLD) ? (cnt + OFF_W'(1)) : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      strb_q    <= STROBE_QUIET;
      ph        <= '0;
      cnt       <= '0;
      last_k    <= '0;
      addr_q    <= '0;
      pc        <= '0;
      have_prev <= 1'b0;
      prev_b6   <= 1'b0;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
      rej_q     <= 1'b0;
      rdv_q     <= 1'b0;
      rd_q      <= '0;
    end else begin
      state  <= nxt;
      strb_q <= strobe_of(nxt);
      ph     <= (nxt != state) ? '0 : ph + PH_W'(1);
      done_q <= (state == ST_PREAD) && acc_end && settled;
      tmo_q  <= (state == ST_PREC) && expired;
      rej_q  <= (state == ST_IDLE) && req_valid && req_write && !req_ok;
      rdv_q  <= (state == ST_RREAD) && acc_end;
      case (state)
        ST_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          cnt    <= '0;
          last_k <= OFF_W'(req_len - LEN_W'(1));
        end
        ST_WHOLD: begin
          if (!last_byte) begin
            cnt    <= cnt + OFF_W'(1);
            addr_q <= addr_q + ADDR_W'(1);
          end else begin
            pc        <= '0;
            have_prev <= 1'b0;
          end
        end
        ST_PREAD: begin
          pc <= pc + PC_W'(1);
          if (acc_end) begin
            prev_b6   <= bus_dq_i[TOGGLE_BIT];
            have_prev <= 1'b1;
          end
        end
        ST_PREC:  pc <= pc + PC_W'(1);
        ST_RREAD: if (acc_end) rd_q <= bus_dq_i;
        default: ;
      endcase
    end
  end

  assign ready     = (state == ST_IDLE);
  assign done      = done_q;
  assign timeout   = tmo_q;
  assign reject    = rej_q;
  assign rd_valid  = rdv_q;
  assign rd_data   = rd_q;
  assign bus_addr  = addr_q;
  assign bus_ce_n  = strb_q.ce_n;
  assign bus_oe_n  = strb_q.oe_n;
  assign bus_we_n  = strb_q.we_n;
  assign bus_dq_oe = strb_q.dq_oe;
  assign bus_dq_o  = buf_rdata;

  // Gap monitor: counts write-enable-high cycles since the last low pulse.
  logic [GAP_W-1:0] gap_cnt;
  logic             seen_pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt    <= '0;
      seen_pulse <= 1'b0;
    end else if (!strb_q.we_n) begin
      gap_cnt    <= '0;
      seen_pulse <= 1'b1;
    end else begin
      if (gap_cnt != GAP_SAT) gap_cnt <= gap_cnt + GAP_W'(1);
      if (state == ST_FETCH) seen_pulse <= 1'b0;
    end
  end

  assert_we_oe_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(!bus_we_n && !bus_oe_n));

  assert_drive_oe_high_R5: assert property (@(posedge clk) disable iff (rst)
    bus_dq_oe |-> bus_oe_n);

  assert_gap_limit_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_we_n) && seen_pulse) |-> (int'(gap_cnt) <= GAP_MAX_CYC));

  assert_reject_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    reject |-> (bus_ce_n && $past(bus_ce_n) && ready));

  assert_done_after_read_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(!bus_oe_n) && ready));

  assert_timeout_after_rec_R8: assert property (@(posedge clk) disable iff (rst)
    timeout |-> ($past(bus_ce_n) && ready));

  assert_read_result_R9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!bus_oe_n));

  assert_one_result_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, timeout, reject, rd_valid}));

  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (rst)
    (!ready && bus_ce_n && !$past(ready)) |=> !bus_oe_n || ready || bus_ce_n);

endmodule

// File: rtl/eeprom_page_host.sv
module eeprom_page_host #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 128,
  parameter int ACCESS_CYC  = 4,
  parameter int STROBE_CYC  = 3,
  parameter int GAP_MAX_CYC = 4,
  parameter int POLL_LIMIT  = 500000,
  parameter int TOGGLE_BIT  = 6,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int LEN_W = $clog2(PAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              buf_we,
  input  logic [OFF_W-1:0]  buf_idx,
  input  logic [DATA_W-1:0] buf_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  output logic              wr_done,
  output logic              wr_timeout,
  output logic              req_reject,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_ce_n,
  output logic              bus_oe_n,
  output logic              bus_we_n,
  output logic [DATA_W-1:0] bus_dq_o,
  output logic              bus_dq_oe,
  input  logic [DATA_W-1:0] bus_dq_i
);

  logic [OFF_W-1:0]  raddr;
  logic [DATA_W-1:0] rdata;
  logic              len_ok;

  eph_pagebuf #(.DEPTH(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_idx),
    .wdata (buf_wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

  eph_req_check #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
    .offset (req_addr[OFF_W-1:0]),
    .len    (req_len),
    .ok     (len_ok)
  );

  eph_seq #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .PAGE_BYTES  (PAGE_BYTES),
    .ACCESS_CYC  (ACCESS_CYC),
    .STROBE_CYC  (STROBE_CYC),
    .GAP_MAX_CYC (GAP_MAX_CYC),
    .POLL_LIMIT  (POLL_LIMIT),
    .TOGGLE_BIT  (TOGGLE_BIT)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_ok    (len_ok),
    .buf_raddr (raddr),
    .buf_rdata (rdata),
    .ready     (req_ready),
    .done      (wr_done),
    .timeout   (wr_timeout),
    .reject    (req_reject),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .bus_addr  (bus_addr),
    .bus_ce_n  (bus_ce_n),
    .bus_oe_n  (bus_oe_n),
    .bus_we_n  (bus_we_n),
    .bus_dq_o  (bus_dq_o),
    .bus_dq_oe (bus_dq_oe),
    .bus_dq_i  (bus_dq_i)
  );

endmodule

// File: tb/eeprom_page_host_tb_top.sv
module eeprom_page_host_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ACC   = 3;
  localparam int STB   = 2;
  localparam int LIMIT = 40;
  localparam int GAPM  = 4;
  localparam int PAGE  = 128;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic buf_we = 1'b0;
  logic [6:0] buf_idx = '0;
  logic [7:0] buf_wdata = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_len = '0;
  logic req_ready, wr_done, wr_timeout, req_reject, rd_valid;
  logic [7:0] rd_data;
  logic [15:0] bus_addr;
  logic bus_ce_n, bus_oe_n, bus_we_n, bus_dq_oe;
  logic [7:0] bus_dq_o;
  logic [7:0] dq_drv = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_page_host #(
    .ACCESS_CYC(ACC), .STROBE_CYC(STB), .GAP_MAX_CYC(GAPM), .POLL_LIMIT(LIMIT)
  ) dut_i (
    .clk(clk), .rst(rst), .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_ready(req_ready), .wr_done(wr_done), .wr_timeout(wr_timeout),
    .req_reject(req_reject), .rd_valid(rd_valid), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_dq_o(bus_dq_o), .bus_dq_oe(bus_dq_oe), .bus_dq_i(dq_drv)
  );

  typedef struct {
    bit ce, oe, we, dqoe;
    int addr, dq;
    bit rdy, dn, tm, rj, rv;
    int rdd;
    string tag;
  } vec_t;

  vec_t expq[$];
  int n_vec = 0, n_bad = 0;
  bit [7:0] bbuf [PAGE];
  bit [7:0] emem [int];
  bit [7:0] dmem [int];
  int dev_k = 0, dev_left = 0;
  bit tog = 0, tog_mode = 0, oe_prev = 1, we_prev = 1;

  function automatic vec_t mk(bit ce, bit oe, bit we, bit dqoe, int addr, int dq,
                              bit rdy, bit dn, bit tm, bit rj, bit rv, int rdd, string tag);
    vec_t v;
    v.ce = ce; v.oe = oe; v.we = we; v.dqoe = dqoe; v.addr = addr; v.dq = dq;
    v.rdy = rdy; v.dn = dn; v.tm = tm; v.rj = rj; v.rv = rv; v.rdd = rdd; v.tag = tag;
    return v;
  endfunction

  function automatic vec_t idle_v(string tag);
    return mk(1, 1, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, tag);
  endfunction

  // EEPROM device model: latches write data on WE rising, answers reads with
  // a bit 6 that flips on each read while the internal write is still busy.
  always @(negedge clk) begin
    if (!rst) begin
      if (!we_prev && bus_we_n && !bus_ce_n) begin
        dmem[int'(bus_addr)] = bus_dq_o;
        dev_left = dev_k;
        tog_mode = 1;
      end
      if (oe_prev && !bus_oe_n && !bus_ce_n) begin
        dq_drv = dmem.exists(int'(bus_addr)) ? dmem[int'(bus_addr)] : 8'h00;
        if (tog_mode) begin
          if (dev_left > 0) begin
            tog = ~tog;
            dev_left--;
          end
          dq_drv[6] = tog;
        end
      end
      we_prev = bus_we_n;
      oe_prev = bus_oe_n;
    end
  end

  // Cycle-by-cycle comparison against the reference model queue.
  always @(negedge clk) begin
    if (!rst) begin
      vec_t e;
      bit ok;
      e = (expq.size() > 0) ? expq.pop_front() : idle_v("R1");
      n_vec++;
      ok = (bus_ce_n == e.ce) && (bus_oe_n == e.oe) && (bus_we_n == e.we) &&
           (bus_dq_oe == e.dqoe) && (req_ready == e.rdy) && (wr_done == e.dn) &&
           (wr_timeout == e.tm) && (req_reject == e.rj) && (rd_valid == e.rv);
      if (!e.ce && (int'(bus_addr) != e.addr)) ok = 0;
      if (e.dqoe && (int'(bus_dq_o) != e.dq)) ok = 0;
      if (e.rv && (int'(rd_data) != e.rdd)) ok = 0;
      if (!ok) begin
        n_bad++;
        $display("FAIL %s t=%0t got ce%b oe%b we%b de%b a=%h d=%h rdy%b dn%b tm%b rj%b rv%b rd=%h exp ce%b oe%b we%b de%b a=%h d=%h rdy%b dn%b tm%b rj%b rv%b rd=%h",
                 e.tag, $time, bus_ce_n, bus_oe_n, bus_we_n, bus_dq_oe, bus_addr, bus_dq_o,
                 req_ready, wr_done, wr_timeout, req_reject, rd_valid, rd_data,
                 e.ce, e.oe, e.we, e.dqoe, e.addr[15:0], e.dq[7:0], e.rdy, e.dn, e.tm, e.rj,
                 e.rv, e.rdd[7:0]);
      end
      if (!bus_we_n && !bus_oe_n) begin
        n_bad++;
        $display("FAIL R5 t=%0t got we_n=0 oe_n=0 exp not both low", $time);
      end
    end
  end

  task automatic wait_empty();
    while (expq.size() != 0) @(posedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic load_buf(int n, int seed);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      bbuf[i]   = 8'((i * 37 + seed) ^ (i >> 2));
      buf_we    = 1'b1;
      buf_idx   = 7'(i);
      buf_wdata = bbuf[i];
    end
    @(posedge clk); #1;
    buf_we = 1'b0;
  endtask

  task automatic do_write(int a, int len, int k, string tag, bit poke);
    bit good;
    wait_empty();
    dev_k = k;
    good = (len >= 1) && (len <= PAGE) && ((a % PAGE) + len <= PAGE);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'(a); req_len = 8'(len);
    expq.push_back(idle_v(tag));
    if (!good) begin
      expq.push_back(mk(1, 1, 1, 0, 0, 0, 1, 0, 0, 1, 0, 0, tag));
    end else begin
      expq.push_back(mk(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag));
      for (int b = 0; b < len; b++) begin
        emem[a + b] = bbuf[b];
        expq.push_back(mk(0, 1, 1, 1, a + b, bbuf[b], 0, 0, 0, 0, 0, 0, tag));
        for (int s = 0; s < STB; s++)
          expq.push_back(mk(0, 1, 0, 1, a + b, bbuf[b], 0, 0, 0, 0, 0, 0, tag));
        expq.push_back(mk(0, 1, 1, 1, a + b, bbuf[b], 0, 0, 0, 0, 0, 0, tag));
      end
      for (int r = 1; r < 1000; r++) begin
        for (int c = 0; c < ACC; c++)
          expq.push_back(mk(0, 0, 1, 0, a + len - 1, 0, 0, 0, 0, 0, 0, 0, tag));
        if (r >= 2 && r > k) begin
          expq.push_back(mk(1, 1, 1, 0, 0, 0, 1, 1, 0, 0, 0, 0, tag));
          break;
        end
        expq.push_back(mk(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag));
        if (r * (ACC + 1) >= LIMIT) begin
          expq.push_back(mk(1, 1, 1, 0, 0, 0, 1, 0, 1, 0, 0, 0, tag));
          break;
        end
      end
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (poke) begin
      repeat (3) @(posedge clk);
      #1;
      req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0042;
      @(posedge clk); #1;
      req_valid = 1'b1; req_write = 1'b1; req_len = 8'd1;
      @(posedge clk); #1;
      req_valid = 1'b0;
    end
  endtask

  task automatic do_read(int a, string tag);
    int ev;
    wait_empty();
    tog_mode = 0;
    ev = emem.exists(a) ? int'(emem[a]) : 0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'(a); req_len = 8'd0;
    expq.push_back(idle_v(tag));
    for (int c = 0; c < ACC; c++)
      expq.push_back(mk(0, 0, 1, 0, a, 0, 0, 0, 0, 0, 0, 0, tag));
    expq.push_back(mk(1, 1, 1, 0, 0, 0, 1, 0, 0, 0, 1, ev, tag));
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, got running exp finished");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (4) @(posedge clk);                       // R1 idle after reset
    load_buf(4, 5);
    do_write(16'h1200, 4, 3, "R3 R4 R6 R7", 0);       // short burst, 4 poll rounds
    do_read(16'h1202, "R9");
    load_buf(PAGE, 91);
    do_write(16'h3480, PAGE, 0, "R3 R4 R7 full", 0);  // full page, minimum polls
    do_read(16'h3480 + PAGE - 1, "R9 last");
    load_buf(2, 200);
    do_write(16'h007F, 1, 5, "R3 R7 page end", 0);
    do_write(16'h0050, 49, 0, "R2 cross", 0);
    do_write(16'h0800, 0, 0, "R2 zero", 0);
    do_write(16'h0800, 129, 0, "R2 long", 0);
    do_write(16'h0801, 128, 0, "R2 offset", 0);
    do_write(16'h0900, 1, 100, "R8 timeout", 0);
    do_write(16'h0A10, 2, 1, "R10 busy", 1);
    do_read(16'h0A11, "R9 R10 after");
    do_read(16'h007F, "R9 single");
    wait_empty();
    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule